// File: doc/BRIEF.md
# Regulator Standby and Reset Sequencer

This block is the control sequencer for an on-chip primary voltage regulator. It runs the regulator in normal mode or in a low-power standby mode, turns on the supply clamp while standby lasts, and drives the internal core reset whenever the regulator comes back up. Software can only put the regulator into standby. It does this by clearing a power-down control bit. After that, only hardware wake events can bring the regulator out of standby: a rising edge on the ignition input, or activity on the bus wake input.

Every exit from standby takes the same path as a cold power-up. The block first waits for the supply comparator to report that the supply is above the release threshold. It then counts a fixed delay of bus clock cycles, 4064 by default. After the count it waits for the external reset pin to read high. Only then is the internal reset released. The power-down control bit is not restored on wake, so initialization software must write it back to one. The synchronized ignition level can be read back, which lets software decide when to enter standby.

All inputs except the ignition input are synchronous to `clk`. The ignition input passes through a two-flop synchronizer. The block has no data streams, so every pin is a plain control or status level.

Top module: `regwake_top`

## Requirements
- R1: A write of 0 to the power-down bit (`pd_wr_en`=1, `pd_wr_data`=0) while `core_rst` is low puts the block into standby at that clock edge, so `stby_en` is high after the edge.
- R2: `clamp_en` is high exactly when `stby_en` is high.
- R3: Once in standby, the block leaves standby on a synchronized rising edge of `ign_async` (it takes effect on the third clock edge after the input changes) or on any clock edge where `bus_wake` is sampled high. Software writes have no effect in standby: `stby_en` stays high and `pd_bit` keeps its value.
- R4: An ignition level that is already high when standby is entered does not wake the block, and neither does a falling edge. A wake needs a low-to-high transition after entry.
- R5: `core_rst` is high in every state except normal operation. If `supply_ok` is sampled low during normal operation, `core_rst` rises at that edge.
- R6: With `ext_rst_pin` high, `core_rst` falls at the DELAY_CYCLES-th clock edge after the edge that first samples `supply_ok` high following a wake or a power-up.
- R7: If `supply_ok` is sampled low during the delay count, the count restarts from zero. The full DELAY_CYCLES count is then needed after `supply_ok` is sampled high again.
- R8: If `ext_rst_pin` is low when the delay ends, `core_rst` stays high. It falls at the first edge that samples `ext_rst_pin` high.
- R9: Leaving standby does not set `pd_bit`: it stays 0 until software writes 1. Writes are ignored while `core_rst` is high.
- R10: `ign_level` shows `ign_async` after two clock edges of synchronization.
- R11: While `rst_n` is low, and after it is released until a release sequence completes, `core_rst`=1, `stby_en`=0, `clamp_en`=0 and `pd_bit`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low power-on reset of the sequencer logic |
| pd_wr_en | input | 1 | Software write strobe for the power-down control bit |
| pd_wr_data | input | 1 | Value to write to the power-down control bit |
| pd_bit | output | 1 | Readback of the power-down control bit |
| ign_async | input | 1 | Asynchronous ignition sense input |
| ign_level | output | 1 | Synchronized ignition level for software |
| bus_wake | input | 1 | Synchronous bus activity wake request |
| supply_ok | input | 1 | Supply-above-release-threshold comparator flag |
| ext_rst_pin | input | 1 | Level of the external reset pin |
| stby_en | output | 1 | Regulator standby enable |
| clamp_en | output | 1 | Supply clamp enable |
| core_rst | output | 1 | Internal reset, active high |

## Verification
The release path is driven in four ways: a clean supply rise with the pin high, which shows whether the count has exactly the right length; a supply dip in the middle of the count, which shows whether the count restarts or resumes; a pin held low past the end of the count, which separates waiting on the count from waiting on the pin; and a supply drop during normal operation. Standby exit is tried with an ignition level that is already high at entry, with a falling ignition edge, with a true rising edge and with a bus wake. These patterns separate level detection from edge detection. Writes made during standby and during reset show whether the write gate holds, and the `pd_bit` readback after a wake shows that the bit is not restored.

// File: rtl/regwake_pkg.sv
package regwake_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL      = 3'd0,
    ST_STANDBY     = 3'd1,
    ST_WAIT_SUPPLY = 3'd2,
    ST_DELAY       = 3'd3,
    ST_WAIT_PIN    = 3'd4
  } seq_state_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/regwake_ign_sync.sv
module regwake_ign_sync
  import regwake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ign_async,
  output logic ign_sync,
  output logic ign_rise
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], ign_async};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign ign_sync = chain_q[SYNC_STAGES-1];
  assign ign_rise = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/regwake_delay.sv
module regwake_delay #(
  parameter int unsigned DELAY_CYCLES = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/regwake_pdbit.sv
module regwake_pdbit (
  input  logic clk,
  input  logic rst_n,
  input  logic in_reset,
  input  logic wr_en,
  input  logic wr_data,
  output logic accept_zero,
  output logic bit_q
);

  logic accept;

  assign accept      = wr_en && !in_reset;
  assign accept_zero = accept && !wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (accept) bit_q <= wr_data;
  end

endmodule

// File: rtl/regwake_fsm.sv
module regwake_fsm
  import regwake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_stby,
  input  logic       ign_rise,
  input  logic       bus_wake,
  input  logic       supply_ok,
  input  logic       ext_rst_pin,
  input  logic       delay_done,
  output seq_state_e state,
  output logic       delay_run
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (!supply_ok)      state_d = ST_WAIT_SUPPLY;
        else if (enter_stby) state_d = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (ign_rise || bus_wake) state_d = ST_WAIT_SUPPLY;
      end
      ST_WAIT_SUPPLY: begin
        if (supply_ok) state_d = ST_DELAY;
      end
      ST_DELAY: begin
        if (!supply_ok)     state_d = ST_WAIT_SUPPLY;
        else if (delay_done) state_d = ext_rst_pin ? ST_NORMAL : ST_WAIT_PIN;
      end
      ST_WAIT_PIN: begin
        if (!supply_ok)      state_d = ST_WAIT_SUPPLY;
        else if (ext_rst_pin) state_d = ST_NORMAL;
      end
      default: state_d = ST_WAIT_SUPPLY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_SUPPLY;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign delay_run = (state_q == ST_DELAY) && supply_ok;

endmodule

// File: rtl/regwake_top.sv
module regwake_top
  import regwake_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 4064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_wr_en,
  input  logic pd_wr_data,
  output logic pd_bit,
  input  logic ign_async,
  output logic ign_level,
  input  logic bus_wake,
  input  logic supply_ok,
  input  logic ext_rst_pin,
  output logic stby_en,
  output logic clamp_en,
  output logic core_rst
);

  seq_state_e state;
  logic       ign_rise;
  logic       enter_stby;
  logic       delay_run;
  logic       delay_done;

  regwake_ign_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ign_async(ign_async),
    .ign_sync (ign_level),
    .ign_rise (ign_rise)
  );

  regwake_pdbit u_pdbit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_reset   (core_rst),
    .wr_en      (pd_wr_en),
    .wr_data    (pd_wr_data),
    .accept_zero(enter_stby),
    .bit_q      (pd_bit)
  );

  regwake_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (delay_run),
    .done (delay_done)
  );

  regwake_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_stby (enter_stby),
    .ign_rise   (ign_rise),
    .bus_wake   (bus_wake),
    .supply_ok  (supply_ok),
    .ext_rst_pin(ext_rst_pin),
    .delay_done (delay_done),
    .state      (state),
    .delay_run  (delay_run)
  );

  assign stby_en  = (state == ST_STANDBY);
  assign clamp_en = (state == ST_STANDBY);
  assign core_rst = (state != ST_NORMAL);

endmodule

// File: rtl/regwake_checker.sv
module regwake_checker (
  input logic clk,
  input logic rst_n,
  input logic pd_wr_en,
  input logic pd_wr_data,
  input logic pd_bit,
  input logic bus_wake,
  input logic supply_ok,
  input logic ext_rst_pin,
  input logic ign_rise,
  input logic stby_en,
  input logic clamp_en,
  input logic core_rst
);

  AST_SW_ENTERS_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && supply_ok && pd_wr_en && !pd_wr_data) |=> stby_en); // R1

  AST_CLAMP_WITH_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    stby_en |-> clamp_en); // R2

  AST_STBY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_en && !bus_wake && !ign_rise) |=> stby_en); // R3

  AST_STBY_IMPLIES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    stby_en |-> core_rst); // R5

  AST_LOW_SUPPLY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> core_rst); // R5

  AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> ($past(ext_rst_pin) && $past(supply_ok))); // R8

  AST_PDBIT_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_bit && !(pd_wr_en && pd_wr_data && !core_rst)) |=> !pd_bit); // R9

endmodule

bind regwake_top regwake_checker i_regwake_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_wr_en   (pd_wr_en),
  .pd_wr_data (pd_wr_data),
  .pd_bit     (pd_bit),
  .bus_wake   (bus_wake),
  .supply_ok  (supply_ok),
  .ext_rst_pin(ext_rst_pin),
  .ign_rise   (ign_rise),
  .stby_en    (stby_en),
  .clamp_en   (clamp_en),
  .core_rst   (core_rst)
);

// File: tb/test_regwake_top.sv
module test_regwake_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned N = 4064;

  logic clk = 1'b0;
  logic rst_n, pd_wr_en, pd_wr_data, ign_async, bus_wake, supply_ok, ext_rst_pin;
  logic pd_bit, ign_level, stby_en, clamp_en, core_rst;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwake_top #(.DELAY_CYCLES(N)) i_regwake_top (
    .clk(clk), .rst_n(rst_n), .pd_wr_en(pd_wr_en), .pd_wr_data(pd_wr_data),
    .pd_bit(pd_bit), .ign_async(ign_async), .ign_level(ign_level),
    .bus_wake(bus_wake), .supply_ok(supply_ok), .ext_rst_pin(ext_rst_pin),
    .stby_en(stby_en), .clamp_en(clamp_en), .core_rst(core_rst)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk); pd_wr_en = 1'b1; pd_wr_data = v;
    @(negedge clk); pd_wr_en = 1'b0;
  endtask

  task automatic bring_up();
    @(negedge clk); supply_ok = 1'b1; ext_rst_pin = 1'b1;
    for (int i = 0; i < N + 20 && core_rst; i++) @(negedge clk);
    chk("R6 bring-up release", core_rst, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 rst core_rst", core_rst, 1'b1);
    chk("R11 rst stby_en", stby_en, 1'b0);
    chk("R11 rst clamp_en", clamp_en, 1'b0);
    chk("R11 rst pd_bit", pd_bit, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 no supply keeps reset", core_rst, 1'b1);
  endtask

  task automatic t_delay_exact();
    @(negedge clk); supply_ok = 1'b1; ext_rst_pin = 1'b1;
    @(posedge clk);
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 reset held before last edge", core_rst, 1'b1);
    @(negedge clk);
    chk("R6 reset released at edge N", core_rst, 1'b0);
    chk("R9 pd_bit still 0 after power-up", pd_bit, 1'b0);
  endtask

  task automatic t_enter_standby();
    sw_write(1'b1);
    chk("R9 pd_bit written 1", pd_bit, 1'b1);
    chk("R1 no standby on write 1", stby_en, 1'b0);
    @(negedge clk); pd_wr_en = 1'b1; pd_wr_data = 1'b0;
    @(negedge clk); pd_wr_en = 1'b0;
    chk("R1 standby right after write 0", stby_en, 1'b1);
    chk("R2 clamp in standby", clamp_en, 1'b1);
    chk("R5 reset in standby", core_rst, 1'b1);
  endtask

  task automatic t_writes_in_standby();
    sw_write(1'b1);
    repeat (3) @(negedge clk);
    chk("R3 write ignored keeps standby", stby_en, 1'b1);
    chk("R3 write ignored keeps pd_bit", pd_bit, 1'b0);
  endtask

  task automatic t_bus_wake();
    @(negedge clk); bus_wake = 1'b1;
    @(negedge clk); bus_wake = 1'b0;
    chk("R3 bus wake leaves standby", stby_en, 1'b0);
    chk("R2 clamp off after wake", clamp_en, 1'b0);
    chk("R5 reset held after wake", core_rst, 1'b1);
  endtask

  task automatic t_ign_sync();
    @(negedge clk); ign_async = 1'b1;
    @(negedge clk);
    chk("R10 ign_level after one edge", ign_level, 1'b0);
    @(negedge clk);
    chk("R10 ign_level after two edges", ign_level, 1'b1);
  endtask

  task automatic t_ign_wake();
    sw_write(1'b0);
    chk("R1 standby with ignition high", stby_en, 1'b1);
    repeat (6) @(negedge clk);
    chk("R4 high level no wake", stby_en, 1'b1);
    ign_async = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4 falling edge no wake", stby_en, 1'b1);
    ign_async = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 not yet woken before third edge", stby_en, 1'b1);
    @(negedge clk);
    chk("R3 ignition rise wakes", stby_en, 1'b0);
  endtask

  task automatic t_pd_after_wake();
    chk("R9 pd_bit 0 after wake release", pd_bit, 1'b0);
    sw_write(1'b1);
    chk("R9 pd_bit set by software", pd_bit, 1'b1);
  endtask

  task automatic t_restart();
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    chk("R5 supply drop in normal resets", core_rst, 1'b1);
    sw_write(1'b0);
    chk("R9 write ignored in reset", pd_bit, 1'b1);
    supply_ok = 1'b1;
    repeat (100) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    @(posedge clk);
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 restarted count still holding", core_rst, 1'b1);
    @(negedge clk);
    chk("R7 full count after restart", core_rst, 1'b0);
  endtask

  task automatic t_pin_hold();
    @(negedge clk); supply_ok = 1'b0; ext_rst_pin = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    repeat (N + 10) @(negedge clk);
    chk("R8 pin low holds reset", core_rst, 1'b1);
    ext_rst_pin = 1'b1;
    @(negedge clk);
    chk("R8 release after pin high", core_rst, 1'b0);
  endtask

  initial begin
    pd_wr_en = 0; pd_wr_data = 0; ign_async = 0; bus_wake = 0;
    supply_ok = 0; ext_rst_pin = 0; rst_n = 0;
    t_reset();
    t_delay_exact();
    t_enter_standby();
    t_writes_in_standby();
    t_bus_wake();
    bring_up();
    t_ign_sync();
    t_ign_wake();
    bring_up();
    t_pd_after_wake();
    t_restart();
    t_pin_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule